// File: doc/BRIEF.md
# Status Register Readback Selector

This block drives the read data byte of an interrupt controller from one of its internal 8-bit registers: the pending-request register, the in-service register, the mask register, or a poll result byte. The host selects a register by writing a command word. The selection is kept, so repeated status reads need no new command. A read with the address line `addr0_i` high returns the mask directly, whatever the stored selection.

A command word with its poll bit set arms a one-shot override. The next read with `addr0_i` low returns the poll result byte. The read after that returns the stored selection again. An init event resets the selection to the request register and drops any armed poll.

The write and read strobes are plain level strobes, not valid/ready streams. There is no back-pressure. A read lasts for as long as `rd_en_i` stays high. `rd_data_o` follows the selection combinationally while the read strobe is high. A write takes effect from the clock edge at which it is sampled.

Top module: `stat_rdsel`

## Requirements
- R1: After reset, and after an `init_i` pulse, a read with `addr0_i`=0 returns the request register.
- R2: A command word with read-enable (bit 1) = 1 and select (bit 0) = 0 makes later `addr0_i`=0 reads return the request register.
- R3: A command word with read-enable (bit 1) = 1 and select (bit 0) = 1 makes later `addr0_i`=0 reads return the in-service register.
- R4: The selection is kept across any number of reads without a new command word.
- R5: A command word with read-enable (bit 1) = 0 leaves the stored selection unchanged.
- R6: A read with `addr0_i`=1 returns the mask register. This holds whatever the stored selection is and whether or not a poll is armed. Such a read does not use up an armed poll.
- R7: A command word with poll (bit 2) = 1 arms a poll. The next read with `addr0_i`=0 returns `poll_i` instead of the selected status register.
- R8: A poll applies to exactly one `addr0_i`=0 read. The read after it returns the stored selection again.
- R9: `rd_data_o` is zero whenever `rd_en_i` is low.
- R10: `init_i` clears an armed poll and sets the selection back to the request register.
- R11: While `rd_en_i` is held high for several cycles, `rd_data_o` stays on the same source. A poll is used up when that strobe ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Initialization event pulse |
| wr_en_i | input | 1 | Command word write strobe |
| cmd_i | input | 8 | Command word: bit0 select, bit1 read-enable, bit2 poll |
| rd_en_i | input | 1 | Read strobe |
| addr0_i | input | 1 | Address line; 1 selects the mask register |
| req_i | input | 8 | Request register value |
| isr_i | input | 8 | In-service register value |
| mask_i | input | 8 | Mask register value |
| poll_i | input | 8 | Poll result byte |
| rd_data_o | output | 8 | Read data byte |

## Verification
The hardest case to reach is the interaction of an armed poll with mask reads and long strobes. The poll must survive reads with `addr0_i` high and must last across a multi-cycle strobe, then expire when that strobe ends. The bench first selects the in-service register and then arms a poll. It then performs a mask read, a three-cycle poll read checked on every cycle, and a further status read. Only the correct design gives mask, poll, poll, poll and then in-service in that order. A second sequence arms a poll and pulses init before reading, so that the reset of both the poll and the selection is visible at the port.

// File: rtl/stat_rdsel_pkg.sv
package stat_rdsel_pkg;
  typedef enum logic [0:0] {
    SEL_REQ = 1'b0,
    SEL_ISR = 1'b1
  } sel_e;

  typedef struct packed {
    logic sel_isr;
    logic rd_enable;
    logic poll;
  } cmd_t;
endpackage

// File: rtl/stat_rdsel_dec.sv
module stat_rdsel_dec #(
  parameter int CMD_W   = 8,
  parameter int SEL_BIT = 0,
  parameter int REN_BIT = 1,
  parameter int POL_BIT = 2
) (
  input  logic [CMD_W-1:0]       cmd_i,
  output stat_rdsel_pkg::cmd_t   cmd_o
);
  always_comb begin
    cmd_o.sel_isr   = cmd_i[SEL_BIT];
    cmd_o.rd_enable = cmd_i[REN_BIT];
    cmd_o.poll      = cmd_i[POL_BIT];
  end
endmodule

// File: rtl/stat_rdsel_state.sv
module stat_rdsel_state (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init_i,
  input  logic                  wr_en_i,
  input  stat_rdsel_pkg::cmd_t  cmd_i,
  input  logic                  rd_en_i,
  input  logic                  addr0_i,
  output stat_rdsel_pkg::sel_e  sel_o,
  output logic                  poll_pend_o
);
  import stat_rdsel_pkg::*;

  sel_e sel_q;
  logic poll_q;
  logic rd_q;
  logic rd_a0_q;
  logic rd_start;
  logic rd_end_stat;

  assign rd_start    = rd_en_i && !rd_q;
  assign rd_end_stat = rd_q && !rd_en_i && !rd_a0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= SEL_REQ;
      poll_q  <= 1'b0;
      rd_q    <= 1'b0;
      rd_a0_q <= 1'b0;
    end else if (init_i) begin
      sel_q   <= SEL_REQ;
      poll_q  <= 1'b0;
      rd_q    <= rd_en_i;
      rd_a0_q <= addr0_i;
    end else begin
      rd_q <= rd_en_i;
      if (rd_start) rd_a0_q <= addr0_i;
      if (rd_end_stat) poll_q <= 1'b0;
      if (wr_en_i) begin
        if (cmd_i.rd_enable) sel_q <= cmd_i.sel_isr ? SEL_ISR : SEL_REQ;
        if (cmd_i.poll) poll_q <= 1'b1;
      end
    end
  end

  assign sel_o       = sel_q;
  assign poll_pend_o = poll_q;

  p_init_default_r1: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (sel_q == SEL_REQ) && !poll_q);
  p_req_pick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !init_i && cmd_i.rd_enable && !cmd_i.sel_isr) |=> sel_q == SEL_REQ);
  p_isr_pick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !init_i && cmd_i.rd_enable && cmd_i.sel_isr) |=> sel_q == SEL_ISR);
  p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((!wr_en_i || !cmd_i.rd_enable) && !init_i) |=> $stable(sel_q));
  p_poll_one_shot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end_stat && !wr_en_i) |=> !poll_q);
  p_poll_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_q && !init_i) |=> $past(poll_q) ? poll_q : 1'b1);
endmodule

// File: rtl/stat_rdsel_mux.sv
module stat_rdsel_mux #(
  parameter int DATA_W = 8
) (
  input  logic                  rd_en_i,
  input  logic                  addr0_i,
  input  stat_rdsel_pkg::sel_e  sel_i,
  input  logic                  poll_pend_i,
  input  logic [DATA_W-1:0]     req_i,
  input  logic [DATA_W-1:0]     isr_i,
  input  logic [DATA_W-1:0]     mask_i,
  input  logic [DATA_W-1:0]     poll_i,
  output logic [DATA_W-1:0]     data_o
);
  import stat_rdsel_pkg::*;

  logic [DATA_W-1:0] status_byte;
  logic [DATA_W-1:0] picked;

  always_comb begin
    status_byte = (sel_i == SEL_ISR) ? isr_i : req_i;
    if (addr0_i)          picked = mask_i;
    else if (poll_pend_i) picked = poll_i;
    else                  picked = status_byte;
  end

  assign data_o = rd_en_i ? picked : '0;
endmodule

// File: rtl/stat_rdsel.sv
module stat_rdsel #(
  parameter int DATA_W = 8,
  parameter int CMD_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              wr_en_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              rd_en_i,
  input  logic              addr0_i,
  input  logic [DATA_W-1:0] req_i,
  input  logic [DATA_W-1:0] isr_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] poll_i,
  output logic [DATA_W-1:0] rd_data_o
);
  import stat_rdsel_pkg::*;

  cmd_t cmd_fields;
  sel_e sel;
  logic poll_pend;

  stat_rdsel_dec #(.CMD_W(CMD_W)) u_dec (
    .cmd_i (cmd_i),
    .cmd_o (cmd_fields)
  );

  stat_rdsel_state u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_i      (init_i),
    .wr_en_i     (wr_en_i),
    .cmd_i       (cmd_fields),
    .rd_en_i     (rd_en_i),
    .addr0_i     (addr0_i),
    .sel_o       (sel),
    .poll_pend_o (poll_pend)
  );

  stat_rdsel_mux #(.DATA_W(DATA_W)) u_mux (
    .rd_en_i     (rd_en_i),
    .addr0_i     (addr0_i),
    .sel_i       (sel),
    .poll_pend_i (poll_pend),
    .req_i       (req_i),
    .isr_i       (isr_i),
    .mask_i      (mask_i),
    .poll_i      (poll_i),
    .data_o      (rd_data_o)
  );

  p_mask_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr0_i) |-> rd_data_o == mask_i);
  p_poll_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !addr0_i && poll_pend) |-> rd_data_o == poll_i);
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |-> rd_data_o == '0);
endmodule

// File: tb/stat_rdsel_tb_top.sv
`timescale 1ns/1ps
module stat_rdsel_tb_top;
  localparam logic [7:0] REQ_V  = 8'hA5;
  localparam logic [7:0] ISR_V  = 8'h3C;
  localparam logic [7:0] MASK_V = 8'h81;
  localparam logic [7:0] POLL_V = 8'h87;
  localparam logic [7:0] CW_REQ  = 8'h02;
  localparam logic [7:0] CW_ISR  = 8'h03;
  localparam logic [7:0] CW_NOP1 = 8'h00;
  localparam logic [7:0] CW_NOP2 = 8'h01;
  localparam logic [7:0] CW_POLL = 8'h04;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] cmd = '0;
  logic rd_en = 1'b0;
  logic addr0 = 1'b0;
  logic [7:0] rd_data;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  stat_rdsel dut_i (
    .clk(clk), .rst_n(rst_n), .init_i(init), .wr_en_i(wr_en), .cmd_i(cmd),
    .rd_en_i(rd_en), .addr0_i(addr0), .req_i(REQ_V), .isr_i(ISR_V),
    .mask_i(MASK_V), .poll_i(POLL_V), .rd_data_o(rd_data)
  );

  task automatic check(input string tag, input logic [7:0] exp);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, exp);
    end
  endtask

  task automatic write_cmd(input logic [7:0] cw);
    @(negedge clk); wr_en = 1'b1; cmd = cw;
    @(negedge clk); wr_en = 1'b0; cmd = '0;
  endtask

  task automatic read_chk(input logic a0, input int cycles, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; addr0 = a0;
    for (int i = 0; i < cycles; i++) begin
      #1 check(tag, exp);
      @(negedge clk);
    end
    rd_en = 1'b0; addr0 = 1'b0;
    #1 check("R9 idle after read", 8'h00);
  endtask

  task automatic t_reset;
    #1 check("R9 idle at reset", 8'h00);
    read_chk(1'b0, 1, REQ_V, "R1 default request");
  endtask

  task automatic t_select;
    write_cmd(CW_ISR);
    read_chk(1'b0, 1, ISR_V, "R3 select in-service");
    read_chk(1'b0, 1, ISR_V, "R4 sticky read 2");
    read_chk(1'b0, 1, ISR_V, "R4 sticky read 3");
    write_cmd(CW_NOP1);
    read_chk(1'b0, 1, ISR_V, "R5 read-enable 0 sel 0 keeps");
    write_cmd(CW_REQ);
    read_chk(1'b0, 1, REQ_V, "R2 select request");
    write_cmd(CW_NOP2);
    read_chk(1'b0, 1, REQ_V, "R5 read-enable 0 sel 1 keeps");
  endtask

  task automatic t_mask;
    write_cmd(CW_ISR);
    read_chk(1'b1, 1, MASK_V, "R6 mask over in-service");
    read_chk(1'b0, 1, ISR_V, "R4 selection after mask read");
  endtask

  task automatic t_poll;
    write_cmd(CW_ISR);
    write_cmd(CW_POLL);
    read_chk(1'b1, 1, MASK_V, "R6 mask while poll armed");
    read_chk(1'b0, 3, POLL_V, "R7 R11 poll held strobe");
    read_chk(1'b0, 1, ISR_V, "R8 back to selection");
    read_chk(1'b0, 1, ISR_V, "R8 poll not re-armed");
  endtask

  task automatic t_init;
    write_cmd(CW_ISR);
    write_cmd(CW_POLL);
    @(negedge clk); init = 1'b1;
    @(negedge clk); init = 1'b0;
    read_chk(1'b0, 1, REQ_V, "R10 R1 init clears poll and selection");
  endtask

  task automatic t_idle;
    @(negedge clk); wr_en = 1'b1; cmd = CW_ISR; addr0 = 1'b1;
    #1 check("R9 idle during write", 8'h00);
    @(negedge clk); wr_en = 1'b0; cmd = '0; addr0 = 1'b0;
    #1 check("R9 idle after write", 8'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_select;
    t_mask;
    t_poll;
    t_init;
    t_idle;
    repeat (2) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule